// File: doc/BRIEF.md
# Byte DMA Transfer and Search Engine

A single-channel engine that moves bytes one at a time between two ports, A and B. Each port has its own address register and addressing options. An address can be held fixed or stepped up or down by one, and the port can point into memory space or I/O space. Once started, the engine reads a byte from the source port and, when searching, compares it against a match value under a mask. When transferring, it then writes the byte to the destination port. It then advances a byte counter and decides whether the block has ended.

Software sets the engine up through a register-load port. It writes a mode byte, the two port option bytes, the two start addresses, a block length, and the match and mask bytes. The engine then reaches the system through a simple request/ready bus master, with one transaction in flight at a time. The engine stops on block end or on a match. It reports why through two sticky status flags, and it raises a one-cycle interrupt pulse each time it stops. In single mode it moves one byte per activation and waits for a resume pulse before the next.

Top module: `bytedma_engine`

## Requirements
- R1: After reset the engine is idle (`busy`=0), `end_flag`, `match_flag`, `irq` and `bus_req` are 0.
- R2: Mode bit 2 set makes port A the source and port B the destination; clear swaps the roles.
- R3: A port option byte with bit 5 set holds that port's address fixed; with bit 5 clear, bit 4 set steps it up by one and bit 4 clear steps it down by one.
- R4: A port option byte with bit 3 set makes that port's accesses go to I/O space (`bus_io`=1); clear means memory space.
- R5: The first byte after a start uses the loaded addresses unchanged; both addresses are stepped before every later byte.
- R6: With mode bit 1 set, a byte equal to the match value on every bit whose mask bit is 0 stops the engine and sets `match_flag`. That byte is still written when transfer is enabled.
- R7: A write to the destination happens only when mode bit 0 is set; otherwise no write request is issued.
- R8: The byte counter (CNT_W bits, cleared on start) counting past its all-ones value ends the block and sets `end_flag`.
- R9: With a nonzero length L, the block ends after L+1 bytes and sets `end_flag`; a length of 0 sets no limit.
- R10: Every stop, whether on end of block or on a match, produces exactly one single-cycle `irq` pulse, seen while `busy` is already 0.
- R11: With mode bit 3 set, bytes follow one another until a stop. With it clear, one byte is moved per `start` or `resume` pulse, and `busy` stays 1 in between.
- R12: While `bus_req` is high and `bus_ready` low, `bus_req`, `bus_we`, `bus_io`, `bus_addr` and `bus_wdata` hold steady into the next cycle.
- R13: A start or a load of either port address clears the counter, `end_flag`, `match_flag` and the first-byte state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Register load strobe (taken only between bytes) |
| ld_sel | input | 3 | Register select: 0 mode, 1/2 options A/B, 3/4 address A/B, 5 length, 6 match, 7 mask |
| ld_data | input | ADDR_W | Load value (low bits used for byte-wide registers) |
| start | input | 1 | Start pulse: clears the state and arms the engine |
| resume | input | 1 | Single mode: permit the next byte |
| bus_req | output | 1 | Bus request valid |
| bus_we | output | 1 | 1 write, 0 read |
| bus_io | output | 1 | 1 I/O space, 0 memory space |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, taken when ready |
| bus_ready | input | 1 | Completes the request in this cycle |
| busy | output | 1 | Engine armed and working |
| end_flag | output | 1 | Stopped on end of block |
| match_flag | output | 1 | Stopped on a search match |
| irq | output | 1 | One-cycle stop pulse |

## Verification
The bench builds the engine with a 16-bit address and an 8-bit byte counter. With an 8-bit counter, the wraparound stop after 256 bytes falls within a short run, which a 16-bit counter would push to 65,536 bytes. The bench's memory and I/O models decode only the low 8 address bits. The defaults for match and mask width (8 bits) are kept, so the masked compare is exercised at its real width. The bus model answers each request one cycle late, so every access spends a cycle with request high and ready low.

// File: rtl/bytedma_pkg.sv
package bytedma_pkg;

   // mode byte fields
   localparam int MB_XFER = 0;
   localparam int MB_SRCH = 1;
   localparam int MB_AFWD = 2;
   localparam int MB_CONT = 3;
   localparam int MODE_W  = 4;

   // port option byte fields
   localparam int PF_IO   = 3;
   localparam int PF_UP   = 4;
   localparam int PF_HOLD = 5;

   // register select codes
   localparam logic [2:0] SEL_MODE = 3'd0;
   localparam logic [2:0] SEL_PFA  = 3'd1;
   localparam logic [2:0] SEL_ADRA = 3'd3;
   localparam logic [2:0] SEL_LEN  = 3'd5;
   localparam logic [2:0] SEL_MVAL = 3'd6;
   localparam logic [2:0] SEL_MSK  = 3'd7;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2,
      ST_FIN  = 2'd3
   } seq_st_e;

   typedef struct packed {
      logic hold;
      logic up;
      logic io;
   } pflag_t;

endpackage

// File: rtl/bytedma_port.sv
module bytedma_port
   import bytedma_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_flags,
   input  logic              ld_addr,
   input  logic [ADDR_W-1:0] ld_data,
   input  logic              step,
   output logic [ADDR_W-1:0] addr,
   output logic              io
);

   pflag_t            fl_q;
   logic [ADDR_W-1:0] a_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fl_q <= '0;
         a_q  <= '0;
      end else begin
         if (ld_flags) begin
            fl_q.hold <= ld_data[PF_HOLD];
            fl_q.up   <= ld_data[PF_UP];
            fl_q.io   <= ld_data[PF_IO];
         end
         if (ld_addr) begin
            a_q <= ld_data;
         end else if (step && !fl_q.hold) begin
            a_q <= fl_q.up ? a_q + ADDR_W'(1) : a_q - ADDR_W'(1);
         end
      end
   end

   assign addr = a_q;
   assign io   = fl_q.io;

   // R3
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && fl_q.hold && !ld_addr && !ld_flags) |=> $stable(addr));

   // R3
   addr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !fl_q.hold && !ld_addr) |=> (addr != $past(addr)));

endmodule

// File: rtl/bytedma_count.sv
module bytedma_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic             ld_len,
   input  logic [CNT_W-1:0] len_in,
   output logic             last_byte
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] len_q;
   logic             wrap_next;
   logic             len_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         len_q <= '0;
      end else begin
         if (ld_len) len_q <= len_in;
         if (clr) cnt_q <= '0;
         else if (inc) cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   // the byte now finishing makes the count cnt_q+1; "count minus one" is cnt_q
   assign wrap_next = &cnt_q;
   assign len_hit   = (len_q != '0) && (cnt_q >= len_q);
   assign last_byte = wrap_next || len_hit;

   // R13
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));

   // R8
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/bytedma_seq.sv
module bytedma_seq
   import bytedma_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              resume,
   input  logic              clr,
   input  logic              m_xfer,
   input  logic              m_srch,
   input  logic              m_cont,
   input  logic [ADDR_W-1:0] src_addr,
   input  logic              src_io,
   input  logic [ADDR_W-1:0] dst_addr,
   input  logic              dst_io,
   input  logic [DATA_W-1:0] match_val,
   input  logic [DATA_W-1:0] match_msk,
   input  logic              last_byte,
   output logic              bus_req,
   output logic              bus_we,
   output logic              bus_io,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_ready,
   output logic              step,
   output logic              cnt_inc,
   output logic              idle,
   output logic              busy,
   output logic              end_flag,
   output logic              match_flag,
   output logic              irq
);

   seq_st_e           st_q;
   logic              working_q;
   logic              go_q;
   logic              first_done_q;
   logic              hit_q;
   logic              end_q;
   logic              mat_q;
   logic              irq_q;
   logic [DATA_W-1:0] data_q;
   logic              launch;
   logic              hit_now;
   logic              stop_now;

   assign idle     = (st_q == ST_IDLE);
   assign launch   = idle && working_q && (m_cont || go_q) && !clr;
   assign step     = launch && first_done_q;
   assign cnt_inc  = (st_q == ST_FIN);
   assign hit_now  = m_srch && (((bus_rdata ^ match_val) & ~match_msk) == '0);
   assign stop_now = hit_q || last_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= ST_IDLE;
         working_q    <= 1'b0;
         go_q         <= 1'b0;
         first_done_q <= 1'b0;
         hit_q        <= 1'b0;
         end_q        <= 1'b0;
         mat_q        <= 1'b0;
         irq_q        <= 1'b0;
         data_q       <= '0;
      end else begin
         irq_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (launch) begin
                  go_q         <= 1'b0;
                  first_done_q <= 1'b1;
                  st_q         <= ST_RD;
               end
            end
            ST_RD: begin
               if (bus_ready) begin
                  data_q <= bus_rdata;
                  hit_q  <= hit_now;
                  st_q   <= m_xfer ? ST_WR : ST_FIN;
               end
            end
            ST_WR: begin
               if (bus_ready) st_q <= ST_FIN;
            end
            ST_FIN: begin
               st_q <= ST_IDLE;
               if (stop_now) begin
                  working_q <= 1'b0;
                  end_q     <= last_byte;
                  mat_q     <= hit_q;
                  irq_q     <= 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
         if (resume && working_q && !launch) go_q <= 1'b1;
         if (clr) begin
            end_q        <= 1'b0;
            mat_q        <= 1'b0;
            first_done_q <= 1'b0;
            hit_q        <= 1'b0;
         end
         if (start) begin
            working_q <= 1'b1;
            go_q      <= 1'b1;
         end
      end
   end

   always_comb begin
      bus_req   = (st_q == ST_RD) || (st_q == ST_WR);
      bus_we    = (st_q == ST_WR);
      bus_io    = bus_we ? dst_io : src_io;
      bus_addr  = bus_we ? dst_addr : src_addr;
      bus_wdata = bus_we ? data_q : '0;
   end

   assign busy       = working_q;
   assign end_flag   = end_q;
   assign match_flag = mat_q;
   assign irq        = irq_q;

   // R10
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R10
   irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !busy);

   // R6
   match_needs_srch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(match_flag) |-> m_srch);

   // R11
   single_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FIN && !stop_now && !m_cont && !resume && !start) |=> !bus_req [*2]);

endmodule

// File: rtl/bytedma_engine.sv
module bytedma_engine
   import bytedma_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [2:0]        ld_sel,
   input  logic [ADDR_W-1:0] ld_data,
   input  logic              start,
   input  logic              resume,
   output logic              bus_req,
   output logic              bus_we,
   output logic              bus_io,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_ready,
   output logic              busy,
   output logic              end_flag,
   output logic              match_flag,
   output logic              irq
);

   localparam int NPORT = 2;

   generate
      if (ADDR_W < 8) begin : g_bad_addr
         $error("bytedma_engine: ADDR_W must be at least 8");
      end
      if (CNT_W > ADDR_W || CNT_W < 2) begin : g_bad_cnt
         $error("bytedma_engine: CNT_W must lie in 2..ADDR_W");
      end
      if (DATA_W > ADDR_W || DATA_W < 1) begin : g_bad_data
         $error("bytedma_engine: DATA_W must lie in 1..ADDR_W");
      end
   endgenerate

   logic              idle;
   logic              ld_ok;
   logic              start_ok;
   logic              clr;
   logic              step;
   logic              cnt_inc;
   logic              last_byte;
   logic [MODE_W-1:0] mode_q;
   logic [DATA_W-1:0] mval_q;
   logic [DATA_W-1:0] msk_q;
   logic [ADDR_W-1:0] p_addr [NPORT];
   logic              p_io   [NPORT];
   logic [NPORT-1:0]  p_ldf;
   logic [NPORT-1:0]  p_lda;
   logic [ADDR_W-1:0] src_addr;
   logic [ADDR_W-1:0] dst_addr;
   logic              src_io;
   logic              dst_io;

   assign ld_ok    = ld_en && idle;
   assign start_ok = start && idle;
   assign clr      = start_ok || (|p_lda);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         mval_q <= '0;
         msk_q  <= '0;
      end else if (ld_ok) begin
         if (ld_sel == SEL_MODE) mode_q <= ld_data[MODE_W-1:0];
         if (ld_sel == SEL_MVAL) mval_q <= ld_data[DATA_W-1:0];
         if (ld_sel == SEL_MSK)  msk_q  <= ld_data[DATA_W-1:0];
      end
   end

   genvar gi;
   generate
      for (gi = 0; gi < NPORT; gi++) begin : g_port
         assign p_ldf[gi] = ld_ok && (ld_sel == SEL_PFA + 3'(gi));
         assign p_lda[gi] = ld_ok && (ld_sel == SEL_ADRA + 3'(gi));
         bytedma_port #(.ADDR_W(ADDR_W)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld_flags (p_ldf[gi]),
            .ld_addr  (p_lda[gi]),
            .ld_data  (ld_data),
            .step     (step),
            .addr     (p_addr[gi]),
            .io       (p_io[gi])
         );
      end
   endgenerate

   always_comb begin
      if (mode_q[MB_AFWD]) begin
         src_addr = p_addr[0];
         src_io   = p_io[0];
         dst_addr = p_addr[1];
         dst_io   = p_io[1];
      end else begin
         src_addr = p_addr[1];
         src_io   = p_io[1];
         dst_addr = p_addr[0];
         dst_io   = p_io[0];
      end
   end

   bytedma_count #(.CNT_W(CNT_W)) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .inc       (cnt_inc),
      .ld_len    (ld_ok && (ld_sel == SEL_LEN)),
      .len_in    (ld_data[CNT_W-1:0]),
      .last_byte (last_byte)
   );

   bytedma_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start_ok),
      .resume     (resume),
      .clr        (clr),
      .m_xfer     (mode_q[MB_XFER]),
      .m_srch     (mode_q[MB_SRCH]),
      .m_cont     (mode_q[MB_CONT]),
      .src_addr   (src_addr),
      .src_io     (src_io),
      .dst_addr   (dst_addr),
      .dst_io     (dst_io),
      .match_val  (mval_q),
      .match_msk  (msk_q),
      .last_byte  (last_byte),
      .bus_req    (bus_req),
      .bus_we     (bus_we),
      .bus_io     (bus_io),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .bus_ready  (bus_ready),
      .step       (step),
      .cnt_inc    (cnt_inc),
      .idle       (idle),
      .busy       (busy),
      .end_flag   (end_flag),
      .match_flag (match_flag),
      .irq        (irq)
   );

   // R12
   bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ready) |=> (bus_req && $stable(bus_we) && $stable(bus_io)
                                   && $stable(bus_addr) && $stable(bus_wdata)));

   // R7
   write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we) |-> mode_q[MB_XFER]);

   // R1
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reset_quiet_chk: assert (!bus_req && !irq);
      end
   end

endmodule

// File: tb/bytedma_engine_test.sv
`timescale 1ns/1ps
module bytedma_engine_test;

   localparam int ADDR_W = 16;
   localparam int DATA_W = 8;
   localparam int CNT_W  = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ld_en = 1'b0;
   logic [2:0]        ld_sel = '0;
   logic [ADDR_W-1:0] ld_data = '0;
   logic              start = 1'b0;
   logic              resume = 1'b0;
   logic              bus_req, bus_we, bus_io;
   logic [ADDR_W-1:0] bus_addr;
   logic [DATA_W-1:0] bus_wdata;
   logic [DATA_W-1:0] bus_rdata;
   logic              bus_ready;
   logic              busy, end_flag, match_flag, irq;

   logic [7:0] mem [256];
   logic [7:0] iom [256];
   int wr_cnt  = 0;
   int irq_cnt = 0;
   int n_chk   = 0;
   int n_bad   = 0;

   always #2.5 clk = ~clk;

   bytedma_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) uut (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
      .start(start), .resume(resume), .bus_req(bus_req), .bus_we(bus_we),
      .bus_io(bus_io), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_ready(bus_ready), .busy(busy),
      .end_flag(end_flag), .match_flag(match_flag), .irq(irq)
   );

   assign bus_rdata = bus_io ? iom[bus_addr[7:0]] : mem[bus_addr[7:0]];

   // bus model: ready one cycle after each request
   always @(posedge clk) begin
      if (!rst_n) begin
         bus_ready <= 1'b0;
      end else begin
         bus_ready <= bus_req && !bus_ready;
         if (bus_req && bus_ready && bus_we) begin
            if (bus_io) iom[bus_addr[7:0]] = bus_wdata;
            else        mem[bus_addr[7:0]] = bus_wdata;
            wr_cnt = wr_cnt + 1;
         end
         if (irq) irq_cnt = irq_cnt + 1;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic load(input logic [2:0] sel, input int val);
      @(negedge clk);
      ld_en = 1'b1; ld_sel = sel; ld_data = ADDR_W'(val);
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic pulse_resume();
      @(negedge clk); resume = 1'b1;
      @(negedge clk); resume = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      @(negedge clk);
      while (busy && n < 5000) begin
         @(negedge clk);
         n++;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic fill();
      for (int i = 0; i < 256; i++) begin
         mem[i] = 8'hEE;
         iom[i] = 8'hEE;
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 busy", busy, 0);
      chk("R1 end_flag", end_flag, 0);
      chk("R1 match_flag", match_flag, 0);
      chk("R1 irq/bus_req", {irq, bus_req}, 0);
   endtask

   // A -> B memory copy, both up, length 3
   task automatic t_copy();
      int w0, i0;
      fill();
      for (int i = 0; i < 8; i++) mem[8'h10 + i] = 8'hA0 + 8'(i);
      load(3'd0, 'h0D); load(3'd1, 'h10); load(3'd2, 'h10);
      load(3'd3, 'h10); load(3'd4, 'h40); load(3'd5, 3);
      w0 = wr_cnt; i0 = irq_cnt;
      pulse_start();
      wait_idle();
      chk("R5 first byte unstepped", mem[8'h40], 8'hA0);
      for (int i = 1; i < 4; i++) chk("R2 A to B copy", mem[8'h40 + i], 8'hA0 + i);
      chk("R9 length 3 stops after 4", mem[8'h44], 8'hEE);
      chk("R9 write count", wr_cnt - w0, 4);
      chk("R9 end_flag", end_flag, 1);
      chk("R10 one irq", irq_cnt - i0, 1);
   endtask

   // B -> A, B fixed in I/O space, A down in memory, length 2
   task automatic t_reverse_io();
      int w0;
      fill();
      iom[8'h20] = 8'h77; iom[8'h21] = 8'h11; mem[8'h20] = 8'h55;
      load(3'd0, 'h09); load(3'd1, 'h00); load(3'd2, 'h28);
      load(3'd3, 'h80); load(3'd4, 'h20); load(3'd5, 2);
      w0 = wr_cnt;
      pulse_start();
      wait_idle();
      chk("R4 I/O source read", mem[8'h80], 8'h77);
      chk("R3 down step", mem[8'h7F], 8'h77);
      chk("R3 down step + fixed source", mem[8'h7E], 8'h77);
      chk("R3 nothing above start", mem[8'h81], 8'hEE);
      chk("R2 B to A count", wr_cnt - w0, 3);
   endtask

   // search only, match 0x5_ under mask 0x0F
   task automatic t_search();
      int w0, i0;
      fill();
      mem[0] = 8'h13; mem[1] = 8'h27; mem[2] = 8'h6A; mem[3] = 8'h4F; mem[4] = 8'h59;
      load(3'd0, 'h0E); load(3'd1, 'h10); load(3'd2, 'h10);
      load(3'd3, 'h00); load(3'd4, 'h90); load(3'd5, 0);
      load(3'd6, 'h50); load(3'd7, 'h0F);
      w0 = wr_cnt; i0 = irq_cnt;
      pulse_start();
      wait_idle();
      chk("R6 match_flag", match_flag, 1);
      chk("R6 no end_flag", end_flag, 0);
      chk("R7 no writes without transfer", wr_cnt - w0, 0);
      chk("R10 irq on match", irq_cnt - i0, 1);
      load(3'd3, 'h00);
      @(negedge clk);
      chk("R13 address load clears match_flag", match_flag, 0);
   endtask

   // search while transfer to I/O space, exact match 0x6A
   task automatic t_search_xfer();
      int w0;
      fill();
      mem[0] = 8'h13; mem[1] = 8'h27; mem[2] = 8'h6A; mem[3] = 8'h4F;
      load(3'd0, 'h0F); load(3'd2, 'h18); load(3'd4, 'h30);
      load(3'd6, 'h6A); load(3'd7, 'h00);
      w0 = wr_cnt;
      pulse_start();
      wait_idle();
      chk("R4 I/O dest byte0", iom[8'h30], 8'h13);
      chk("R6 matching byte written", iom[8'h32], 8'h6A);
      chk("R6 stop after match", iom[8'h33], 8'hEE);
      chk("R6 write count", wr_cnt - w0, 3);
      chk("R6 match_flag", match_flag, 1);
   endtask

   // length 0 runs to counter wrap (256 bytes with CNT_W=8)
   task automatic t_wrap();
      int w0;
      fill();
      for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5C;
      load(3'd0, 'h0D); load(3'd1, 'h10); load(3'd2, 'h28);
      load(3'd3, 'h00); load(3'd4, 'h40); load(3'd5, 0);
      w0 = wr_cnt;
      pulse_start();
      wait_idle();
      chk("R8 wrap byte count", wr_cnt - w0, 256);
      chk("R8 end_flag", end_flag, 1);
      chk("R8 last byte", iom[8'h40], 8'hA3);
      chk("R13 start cleared old match", match_flag, 0);
   endtask

   // length 1 boundary
   task automatic t_len1();
      int w0;
      fill();
      load(3'd0, 'h0D); load(3'd1, 'h10); load(3'd2, 'h10);
      load(3'd3, 'h10); load(3'd4, 'h50); load(3'd5, 1);
      mem[8'h10] = 8'h31; mem[8'h11] = 8'h32;
      w0 = wr_cnt;
      pulse_start();
      wait_idle();
      chk("R9 length 1 count", wr_cnt - w0, 2);
      chk("R9 length 1 tail", mem[8'h52], 8'hEE);
   endtask

   // single mode
   task automatic t_single();
      int w0, i0;
      fill();
      mem[8'h10] = 8'hA0; mem[8'h11] = 8'hA1;
      load(3'd0, 'h05); load(3'd1, 'h10); load(3'd2, 'h10);
      load(3'd3, 'h10); load(3'd4, 'h60); load(3'd5, 0);
      w0 = wr_cnt; i0 = irq_cnt;
      pulse_start();
      repeat (30) @(negedge clk);
      chk("R11 one byte per start", wr_cnt - w0, 1);
      chk("R11 busy held", busy, 1);
      pulse_resume();
      repeat (30) @(negedge clk);
      chk("R11 one byte per resume", wr_cnt - w0, 2);
      chk("R11 second byte", mem[8'h61], 8'hA1);
      chk("R11 no irq", irq_cnt - i0, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      fill();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_copy();
      t_reverse_io();
      t_search();
      t_search_xfer();
      t_wrap();
      t_len1();
      t_single();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule